// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a single-port synchronous static memory of 32-bit words meant to sit on a shared processor bus, where reads and writes may alternate on every clock with no idle cycle between them. Every input is captured on the rising clock edge. A read address presented in one cycle yields its data two cycles later. A write address presented in one cycle takes its data from the bus two cycles later. Because the two latencies match, the data bus carries one transfer per clock whatever the mix of operations.

Each cycle either loads a fresh address or steps a 2-bit burst counter. A stepped cycle continues the operation and selection of the last load, and walks the low two address bits in one of two orders, chosen when the burst is loaded. Writes go through four active-low byte-lane enables. Three chip selects gate every load. An active-low clock enable freezes the whole pipeline. The bidirectional bus is modelled as `din`, `dout` and an output-enable flag `oe`.

Top module: `nt_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, `oe` is 0 and `dout` is 0 until a read completes.
- R2: A selected read issued in active cycle n drives `oe`=1 and the addressed word on `dout` after the clock edge of active cycle n+2.
- R3: A selected write issued in active cycle n stores the value on `din` during active cycle n+2. In the cycle where its data slot completes, `oe` is 0.
- R4: Byte enables are active low. `bw_n[0]` gates bits 7:0, `bw_n[1]` bits 15:8, `bw_n[2]` bits 23:16 and `bw_n[3]` bits 31:24. A lane whose enable is high keeps its stored byte.
- R5: Reads and writes may alternate on consecutive active cycles. A read issued right after a write to the same word returns the newly written bytes merged with the unwritten old bytes.
- R6: A load is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it and the steps that follow it are deselects: nothing is written and `oe` is 0 two active cycles later.
- R7: With `ld_n`=0 the address is taken from `addr` and the counter clears. With `ld_n`=1 the counter advances by one, and the cycle repeats the read/write kind and selection of the last load, using the current `bw_n` and `din` data slot.
- R8: When `mode`=0 at the load, the stepped address low bits are (start low bits) XOR (counter), and the upper bits are unchanged.
- R9: When `mode`=1 at the load, the stepped address low bits are (start low bits + counter) mod 4, and the upper bits are unchanged.
- R10: While `cke_n`=1 every input is ignored, no write happens, and `dout` and `oe` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads `addr`, high advances the burst |
| we_n | input | 1 | Low for write, high for read (taken on loads) |
| bw_n | input | 4 | Active-low byte-lane write enables |
| mode | input | 1 | Burst order at load: 0 interleaved, 1 linear |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data, taken two active cycles after its address |
| dout | output | 32 | Read data |
| oe | output | 1 | High when `dout` carries read data |

## Verification
A wrong burst counter or order bit shows up as a wrong word on `dout` two active cycles after the stepped read. The bench walks every start offset in both orders, so such a fault appears within one burst. A bad byte-lane mask, forwarding path or chip-select decode leaves a stale or altered word in the array. That word is seen at the next read of the address, which the bench issues either at once or in a full sweep of the array. A pipeline that fails to freeze shows as `dout` or `oe` changing across a gated cycle, or as data being written during one.

// File: rtl/nt_burst_sram.sv
module nt_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke_n,
  input  logic                  ce1_n,
  input  logic                  ce2,
  input  logic                  ce3_n,
  input  logic                  ld_n,
  input  logic                  we_n,
  input  logic [DATA_W/8-1:0]   bw_n,
  input  logic                  mode,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     din,
  output logic [DATA_W-1:0]     dout,
  output logic                  oe
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  wire go  = !cke_n;
  wire sel = !ce1_n && ce2 && !ce3_n;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              lin_q, act_q, wr_q;

  wire [1:0] cnt_nx = cnt_q + 2'd1;
  wire [1:0] lo_adv = lin_q ? (base_q[1:0] + cnt_nx) : (base_q[1:0] ^ cnt_nx);
  wire [ADDR_W-1:0] ea = ld_n ? {base_q[ADDR_W-1:2], lo_adv} : addr;
  wire ev = ld_n ? act_q : sel;
  wire ew = ld_n ? wr_q : !we_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_q <= '0; cnt_q <= '0; lin_q <= 1'b0; act_q <= 1'b0; wr_q <= 1'b0;
    end else if (go) begin
      if (!ld_n) begin
        base_q <= addr; cnt_q <= '0; lin_q <= mode; act_q <= sel; wr_q <= !we_n;
      end else
        cnt_q <= cnt_nx;
    end

  logic              s1_v, s1_w, s2_v, s2_w;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_b, s2_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_w <= 1'b0; s1_a <= '0; s1_b <= '1;
      s2_v <= 1'b0; s2_w <= 1'b0; s2_a <= '0; s2_b <= '1;
    end else if (go) begin
      s1_v <= ev;   s1_w <= ew;   s1_a <= ea;   s1_b <= bw_n;
      s2_v <= s1_v; s2_w <= s1_w; s2_a <= s1_a; s2_b <= s1_b;
    end

  wire hit = s2_v && s2_w && (s2_a == s1_a);
  logic [DATA_W-1:0] rd_mix;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_mix[i*8 +: 8] = (hit && !s2_b[i]) ? din[i*8 +: 8] : mem[s1_a][i*8 +: 8];
  end

  always_ff @(posedge clk)
    if (go && s2_v && s2_w)
      for (int i = 0; i < LANES; i++)
        if (!s2_b[i]) mem[s2_a][i*8 +: 8] <= din[i*8 +: 8];

  logic [DATA_W-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata_q <= '0; dout <= '0; oe <= 1'b0;
    end else if (go) begin
      rdata_q <= rd_mix;
      oe      <= s2_v && !s2_w;
      if (s2_v && !s2_w) dout <= rdata_q;
    end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !oe && dout == '0);
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s2_v && !s2_w) |=> oe);
  assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !(s2_v && !s2_w)) |=> !oe);
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n) |=> cnt_q == 2'd0 && base_q == $past(addr));
  assert_step_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld_n) |=> cnt_q == $past(cnt_q) + 2'd1);
  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dout) && $stable(oe) && $stable(s1_a) && $stable(cnt_q));
endmodule

// File: tb/nt_burst_sram_bench.sv
module nt_burst_sram_bench;
  logic clk = 1'b0, rst_n = 1'b0, cke_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic ld_n = 1'b0, we_n = 1'b1, mode = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [5:0] addr = '0;
  logic [31:0] din = '0, dout;
  logic oe;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  nt_burst_sram u_nt_burst_sram (.clk, .rst_n, .cke_n, .ce1_n, .ce2, .ce3_n, .ld_n,
    .we_n, .bw_n, .mode, .addr, .din, .dout, .oe);

  logic [31:0] m [64];
  logic [5:0] bb; logic [1:0] bc; logic bl, bact, bwr;
  logic q1_v, q1_w, q2_v, q2_w;
  logic [5:0] q1_a, q2_a; logic [3:0] q1_b, q2_b; logic [31:0] q1_d, q2_d;
  string q1_t, q2_t;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int salt);
    return 32'h9E3779B9 * (a + salt * 97 + 1) ^ (salt << 24);
  endfunction

  task automatic cyc(input bit ck_n, input bit ldn, input bit wen, input bit [2:0] ce,
                     input logic [3:0] bwn, input bit md, input logic [5:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] pd; logic po; logic [5:0] ea; logic [1:0] lo;
    @(negedge clk);
    cke_n = ck_n; ld_n = ldn; we_n = wen; bw_n = bwn; mode = md; addr = a;
    ce1_n = !ce[0]; ce2 = ce[1]; ce3_n = !ce[2];
    din = (q2_v && q2_w && !ck_n) ? q2_d : 32'hDEAD_0000 ^ {26'd0, a};
    pd = dout; po = oe;
    @(posedge clk); #1;
    if (ck_n) begin
      chk(dout == pd && oe == po, "R10", {dout[30:0], oe}, {pd[30:0], po});
      return;
    end
    if (!ldn) begin
      bb = a; bc = 2'd0; bl = md; bact = &ce; bwr = !wen; ea = a;
    end else begin
      bc = bc + 2'd1;
      lo = bl ? bb[1:0] + bc : bb[1:0] ^ bc;
      ea = {bb[5:2], lo};
    end
    if (q2_v && q2_w)
      for (int i = 0; i < 4; i++) if (!q2_b[i]) m[q2_a][i*8 +: 8] = q2_d[i*8 +: 8];
    if (q2_v && !q2_w) begin
      chk(oe == 1'b1, q2_t, {31'd0, oe}, 32'd1);
      chk(dout == m[q2_a], q2_t, dout, m[q2_a]);
    end else
      chk(oe == 1'b0, q2_t, {31'd0, oe}, 32'd0);
    q2_v = q1_v; q2_w = q1_w; q2_a = q1_a; q2_b = q1_b; q2_d = q1_d; q2_t = q1_t;
    q1_v = bact; q1_w = bwr; q1_a = ea; q1_b = bwn; q1_d = d; q1_t = tag;
  endtask

  task automatic flush();
    cyc(0, 0, 1, 3'b000, 4'hF, 0, 0, 0, "R6");
    cyc(0, 0, 1, 3'b000, 4'hF, 0, 0, 0, "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R2 watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    q1_v = 0; q2_v = 0; q1_w = 0; q2_w = 0; q1_a = 0; q2_a = 0; q1_b = '1; q2_b = '1;
    q1_d = 0; q2_d = 0; q1_t = "R1"; q2_t = "R1";
    bb = 0; bc = 0; bl = 0; bact = 0; bwr = 0;
    repeat (3) @(posedge clk); #1;
    chk(oe == 1'b0, "R1", {31'd0, oe}, 0);
    chk(dout == 0, "R1", dout, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(oe == 1'b0 && dout == 0, "R1", dout, 0);

    for (int a = 0; a < 64; a++) cyc(0, 0, 0, 3'b111, 4'h0, 0, a, pat(a, 1), "R3");
    for (int a = 0; a < 64; a++) cyc(0, 0, 1, 3'b111, 4'hF, 0, a, 0, "R2");

    for (int a = 0; a < 16; a++) begin
      cyc(0, 0, 0, 3'b111, a[3:0], 0, a, pat(a, 2), "R4");
      cyc(0, 0, 1, 3'b111, 4'hF, 0, a, 0, "R4");
    end
    for (int i = 0; i < 32; i++) begin
      cyc(0, 0, 0, 3'b111, 4'(i * 5), 0, 20 + i % 8, pat(i, 3), "R5");
      cyc(0, 0, 1, 3'b111, 4'hF, 0, 20 + i % 8, 0, "R5");
      cyc(0, 0, 1, 3'b111, 4'hF, 0, 20 + (i + 3) % 8, 0, "R5");
    end

    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 1, 3'b111, 4'hF, md[0], 32 + s, 0, md ? "R9" : "R8");
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 3'b000, 4'hF, 0, 0, 0, md ? "R9" : "R8");
      end
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 0, 3'b111, 4'h0, md[0], 40 + 4 * md + s, pat(s, 4 + md), "R7");
        for (int k = 0; k < 3; k++)
          cyc(0, 1, 1, 3'b000, 4'(k * 3), 1, 0, pat(k + s, 6 + md), "R7");
        for (int k = 0; k < 4; k++) cyc(0, 0, 1, 3'b111, 4'hF, 0, 40 + 4 * md + k, 0, "R7");
      end

    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, (k == 3) ? 3'b000 : 3'(3'b111 & ~(3'b1 << k)), 4'h0, 0, 50, 32'hBAD0_0000 + k, "R6");
      cyc(0, 1, 0, 3'b111, 4'h0, 0, 0, 32'hBAD1_0000 + k, "R6");
      for (int a = 48; a < 52; a++) cyc(0, 0, 1, 3'b111, 4'hF, 0, a, 0, "R6");
    end

    cyc(0, 0, 1, 3'b111, 4'hF, 0, 3, 0, "R10");
    cyc(0, 0, 0, 3'b111, 4'h0, 0, 60, pat(60, 9), "R10");
    for (int k = 0; k < 3; k++) cyc(1, k[0], 0, 3'b111, 4'h0, 1, 6'(61 + k), 32'hFFFF_FFFF, "R10");
    cyc(0, 0, 1, 3'b111, 4'hF, 0, 60, 0, "R10");
    for (int k = 0; k < 2; k++) cyc(1, 0, 0, 3'b111, 4'h0, 0, 61, 32'h1234_5678, "R10");
    cyc(0, 0, 1, 3'b111, 4'hF, 0, 61, 0, "R10");
    cyc(0, 0, 1, 3'b111, 4'hF, 0, 62, 0, "R10");
    flush();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule